// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes 16-bit two's-complement stereo samples from a three-wire serial link (a bit clock, a word-select line and serial data) and hands each complete left/right pair to a converter core as two parallel words with a one-cycle strobe. Every link pin is brought into the block's own clock domain through a synchronizer, and the rising edge of the bit clock is found by oversampling. A bit is taken on each such edge.

A format input chooses between two link formats. In multiplexed format both channels share the main data pin and take turns. The auxiliary pin is then a polarity control that says which word-select level marks the left word. In simultaneous format the main pin carries the right channel and the auxiliary pin carries the left channel, both at the same time, and every word-select transition closes a stereo pair. In both formats the two outputs are loaded in the same clock cycle. A change on the format input only takes effect at a frame boundary.

Top module: `serial_audio_rx`

## Requirements
- R1: Words are received most significant bit first. Output bit 15 holds the first of the last 16 bits received for that word. Outputs are two's complement, passed through unchanged.
- R2: In multiplexed format (format input 0) with the auxiliary pin at 1, the word sent while word-select is high is the left sample and the word sent while it is low is the right sample. A pair is delivered when the right word is closed by the next word-select transition.
- R3: In multiplexed format with the auxiliary pin at 0, the left sample is the word sent while word-select is low and the right sample is the word sent while it is high.
- R4: In simultaneous format (format input 1), the main data pin carries the right sample and the auxiliary pin carries the left sample. Every word-select transition delivers the pair shifted in since the previous transition.
- R5: Both outputs change only in the clock cycle in which the strobe is high. The strobe is high for exactly one cycle per delivered pair.
- R6: If a word has more than 16 bits, only the last 16 bits received are kept.
- R7: If a word has fewer than 16 bits, the bits received occupy the top of the output and the lower bits are zero.
- R8: The format input is taken only at a frame boundary: the end of a right word in multiplexed format, or any word-select transition in simultaneous format. A pulse on it that spans only a left-word boundary has no effect.
- R9: While reset (synchronous, active low) is held, both outputs are zero and the strobe is low. The stored word-select level is treated as low.
- R10: Data pins are sampled at the rising edge of the bit clock. A change on a data pin while the bit clock stays high has no effect on the received word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; must sample each bit-clock phase at least twice |
| rst_n | input | 1 | Synchronous reset, active low |
| bck | input | 1 | Serial bit clock, asynchronous to clk |
| ws | input | 1 | Word-select line; a transition marks a word boundary |
| sdata | input | 1 | Main serial data: both channels (multiplexed) or right channel (simultaneous) |
| aux_pin | input | 1 | Left/word-select polarity (multiplexed) or left serial data (simultaneous) |
| fmt_sel | input | 1 | Format request: 0 multiplexed, 1 simultaneous |
| left_pcm | output | 16 | Left sample, two's complement |
| right_pcm | output | 16 | Right sample, two's complement |
| pcm_valid | output | 1 | One-cycle strobe when a new pair is loaded |

## Verification
On every cycle, the assertions check four things: the strobe lasts one cycle, the outputs hold while the strobe is low, the strobe follows a bit-clock edge, and the word counters stay within the word length. They also check that the active format only moves at a frame boundary, and that reset clears the outputs. Only the bench scenarios can show which word becomes left or right under each polarity and format, the alignment of long and short words, and that a format pulse straddling a left boundary leaves the decoding alone. They can also show that data wiggled during the bit-clock high phase is ignored. The scoreboard compares every delivered pair against values computed from the sent bits.

// File: rtl/sai_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the serial audio receiver.
// Assumes two data lanes: lane 0 is the main pin, lane 1 the auxiliary pin.
package sai_rx_pkg;
    typedef enum logic {
        FMT_MUX = 1'b0,
        FMT_SIM = 1'b1
    } fmt_e;

    localparam int LANES     = 2;
    localparam int LANE_MAIN = 0;
    localparam int LANE_AUX  = 1;
endpackage

// File: rtl/sai_rx_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes every bit is a level; all bits get the same latency so that
// pins that change together stay aligned after the synchronizer.
module sai_rx_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // shift the pins through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sai_rx_lane.sv
`timescale 1ns/1ps
// One serial data lane: an MSB-first shift register with a saturating bit count.
// On a boundary tick the new bit starts a fresh word. word_q is the word
// received so far, moved to the top so short words fill with zeros below.
// Assumes tick is a single-cycle pulse per bit-clock rising edge.
module sai_rx_lane #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              boundary,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_q,
    output logic [CNT_W-1:0]  cnt_q
);
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  shamt;

    // shift in one bit per tick, restarting on a word boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (boundary) begin
                sr    <= {{(WORD_W-1){1'b0}}, bit_in};
                cnt_q <= CNT_W'(1);
            end else begin
                sr <= {sr[WORD_W-2:0], bit_in};
                if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // move a partial word to the top of the output
    always_comb begin
        shamt  = CNT_W'(WORD_W) - cnt_q;
        word_q = sr << shamt;
    end
endmodule

// File: rtl/sai_rx_frame.sv
`timescale 1ns/1ps
// Frame control: finds word boundaries and decides which completed word is
// left or right. It holds the left word until its partner arrives, loads both
// outputs together, and takes a new format only at frame boundaries.
// Assumes the polarity pin is steady during the last bit of each
// multiplexed word.
module sai_rx_frame
    import sai_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ws_s,
    input  logic              pol_s,
    input  logic              fmt_pin,
    input  logic [WORD_W-1:0] word_main,
    input  logic [WORD_W-1:0] word_aux,
    output logic              boundary,
    output logic              mode_evt,
    output fmt_e              fmt_act,
    output logic [WORD_W-1:0] left_q,
    output logic [WORD_W-1:0] right_q,
    output logic              valid_q
);
    logic              ws_prev;
    logic              pol_prev;
    logic [WORD_W-1:0] stage_l;
    logic              left_have;
    logic              left_done;
    logic              right_done;
    logic              sim_done;
    logic              pair_go;

    // classify the boundary of the word just completed
    always_comb begin
        boundary   = tick && (ws_s != ws_prev);
        left_done  = boundary && (fmt_act == FMT_MUX) && (ws_prev == pol_prev);
        right_done = boundary && (fmt_act == FMT_MUX) && (ws_prev != pol_prev);
        sim_done   = boundary && (fmt_act == FMT_SIM);
        pair_go    = (right_done && left_have) || sim_done;
        mode_evt   = right_done || sim_done;
    end

    // remember word-select and polarity as seen at the previous bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev  <= 1'b0;
            pol_prev <= 1'b0;
        end else if (tick) begin
            ws_prev  <= ws_s;
            pol_prev <= pol_s;
        end
    end

    // hold the left word of a multiplexed frame until its partner completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_l   <= '0;
            left_have <= 1'b0;
        end else if (left_done) begin
            stage_l   <= word_main;
            left_have <= 1'b1;
        end else if (pair_go) begin
            left_have <= 1'b0;
        end
    end

    // load both outputs together and raise the strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= pair_go;
            if (pair_go) begin
                left_q  <= (fmt_act == FMT_SIM) ? word_aux : stage_l;
                right_q <= word_main;
            end
        end
    end

    // take the requested format only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_act <= FMT_MUX;
        end else if (mode_evt) begin
            fmt_act <= fmt_pin ? FMT_SIM : FMT_MUX;
        end
    end
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
// Dual-format serial audio receiver, top level.
// Synchronizes the link pins, finds bit-clock rising edges, shifts both lanes
// and passes completed words to the frame control.
// Assumes clk samples each bit-clock high and low phase at least twice.
module serial_audio_rx
    import sai_rx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck,
    input  logic              ws,
    input  logic              sdata,
    input  logic              aux_pin,
    input  logic              fmt_sel,
    output logic [WORD_W-1:0] left_pcm,
    output logic [WORD_W-1:0] right_pcm,
    output logic              pcm_valid
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PIN_W = 5;
    localparam int P_BCK = 0;
    localparam int P_WS  = 1;
    localparam int P_MAIN = 2;
    localparam int P_AUX = 3;
    localparam int P_FMT = 4;

    logic [PIN_W-1:0]                  pins_raw;
    logic [PIN_W-1:0]                  pins_s;
    logic                              bck_d;
    logic                              tick;
    logic [LANES-1:0]                  lane_bit;
    logic [LANES-1:0][WORD_W-1:0]      lane_word;
    logic [LANES-1:0][CNT_W-1:0]       lane_cnt;
    logic                              boundary;
    logic                              mode_evt;
    fmt_e                              fmt_act;

    assign pins_raw = {fmt_sel, aux_pin, sdata, ws, bck};

    sai_rx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    // delayed bit clock for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bck_d <= 1'b0;
        else        bck_d <= pins_s[P_BCK];
    end

    assign tick = pins_s[P_BCK] & ~bck_d;
    assign lane_bit[LANE_MAIN] = pins_s[P_MAIN];
    assign lane_bit[LANE_AUX]  = pins_s[P_AUX];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sai_rx_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .boundary (boundary),
            .bit_in   (lane_bit[g]),
            .word_q   (lane_word[g]),
            .cnt_q    (lane_cnt[g])
        );
    end

    sai_rx_frame #(.WORD_W(WORD_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ws_s      (pins_s[P_WS]),
        .pol_s     (pins_s[P_AUX]),
        .fmt_pin   (pins_s[P_FMT]),
        .word_main (lane_word[LANE_MAIN]),
        .word_aux  (lane_word[LANE_AUX]),
        .boundary  (boundary),
        .mode_evt  (mode_evt),
        .fmt_act   (fmt_act),
        .left_q    (left_pcm),
        .right_q   (right_pcm),
        .valid_q   (pcm_valid)
    );
endmodule

// File: rtl/serial_audio_rx_chk.sv
`timescale 1ns/1ps
// Property checker for serial_audio_rx, attached with bind.
// Watches the strobe, the output hold, the format changes and the lane counters.
module serial_audio_rx_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int LANES  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic                     mode_evt,
    input logic                     fmt_act,
    input logic [LANES*CNT_W-1:0]   lane_cnt,
    input logic [WORD_W-1:0]        left_pcm,
    input logic [WORD_W-1:0]        right_pcm,
    input logic                     pcm_valid
);
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> ($stable(left_pcm) && $stable(right_pcm))); // R5

    AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(tick)); // R10

    AST_FMT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_evt |=> $stable(fmt_act)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (left_pcm == '0 && right_pcm == '0 && !pcm_valid)); // R9

    for (genvar g = 0; g < LANES; g++) begin : g_cnt
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            lane_cnt[g*CNT_W +: CNT_W] <= CNT_W'(WORD_W)); // R6
    end
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode_evt  (mode_evt),
    .fmt_act   (fmt_act),
    .lane_cnt  (lane_cnt),
    .left_pcm  (left_pcm),
    .right_pcm (right_pcm),
    .pcm_valid (pcm_valid)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: frame tasks push expected pairs, a monitor pops on each strobe.
module serial_audio_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        ws = 1'b0;
    logic        sdata = 1'b0;
    logic        aux_pin = 1'b0;
    logic        fmt_sel = 1'b0;
    logic [15:0] left_pcm;
    logic [15:0] right_pcm;
    logic        pcm_valid;

    typedef struct {
        logic [15:0] l;
        logic [15:0] r;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0;
    int   bad   = 0;

    always #2.5 clk = ~clk;

    serial_audio_rx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck       (bck),
        .ws        (ws),
        .sdata     (sdata),
        .aux_pin   (aux_pin),
        .fmt_sel   (fmt_sel),
        .left_pcm  (left_pcm),
        .right_pcm (right_pcm),
        .pcm_valid (pcm_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected output for the low n bits of v sent MSB first (R6, R7)
    function automatic logic [15:0] fit(input logic [31:0] v, input int n);
        logic [31:0] m;
        if (n >= 16) return v[15:0];
        m = (32'h1 << n) - 32'h1;
        return 16'((v & m) << (16 - n));
    endfunction

    // one bit; data wiggles while bck is high to exercise R10
    task automatic send_bit(input bit d0, input bit d1, input bit wsv, input bit sim);
        @(negedge clk);
        bck = 1'b0; sdata = d0; ws = wsv;
        if (sim) aux_pin = d1;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (2) @(negedge clk);
        sdata = ~d0;
        if (sim) aux_pin = ~d1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] v0, input logic [31:0] v1,
                             input int n, input bit wsv, input bit sim);
        for (int i = n - 1; i >= 0; i--) send_bit(v0[i], v1[i], wsv, sim);
    endtask

    task automatic mux_frame(input logic [31:0] l, input int nl,
                             input logic [31:0] r, input int nr,
                             input bit pol, input string tag);
        exp_t e;
        send_word(l, 32'h0, nl, pol, 1'b0);
        send_word(r, 32'h0, nr, ~pol, 1'b0);
        e.l = fit(l, nl); e.r = fit(r, nr); e.tag = tag;
        sb_q.push_back(e);
    endtask

    // simultaneous frame: right on main pin, left on auxiliary pin
    task automatic sim_frame(input logic [31:0] l, input logic [31:0] r,
                             input int n, input bit wsv, input string tag);
        exp_t e;
        send_word(r, l, n, wsv, 1'b1);
        e.l = fit(l, n); e.r = fit(r, n); e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(left_pcm == 16'h0, "R9", "left in reset", 32'(left_pcm), 32'h0);
        check(right_pcm == 16'h0, "R9", "right in reset", 32'(right_pcm), 32'h0);
        check(pcm_valid == 1'b0, "R9", "strobe in reset", 32'(pcm_valid), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        repeat (30) @(negedge clk);
        check(sb_q.size() == 0, tag, "pairs still pending", 32'(sb_q.size()), 32'h0);
    endtask

    // monitor: compare every delivered pair with the oldest expected one
    always @(negedge clk) begin
        if (rst_n && pcm_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected strobe", 32'(left_pcm), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(left_pcm == e.l, e.tag, "left", 32'(left_pcm), 32'(e.l));
                check(right_pcm == e.r, e.tag, "right", 32'(right_pcm), 32'(e.r));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t e;
        // multiplexed, left while word-select high
        aux_pin = 1'b1; fmt_sel = 1'b0; ws = 1'b0;
        do_reset();
        mux_frame(32'h1234, 16, 32'hABCD, 16, 1'b1, "R1 R2 R10");
        mux_frame(32'h8000, 16, 32'h7FFF, 16, 1'b1, "R2");
        mux_frame(32'hFFFF, 16, 32'h0001, 16, 1'b1, "R2");
        mux_frame(32'hF5A5A, 20, 32'h2AB, 10, 1'b1, "R6 R7");
        // format pulse spanning only the left-to-right boundary
        for (int i = 15; i >= 0; i--) begin
            if (i == 2) fmt_sel = 1'b1;
            send_bit(1'(16'hC3C3 >> i), 1'b0, 1'b1, 1'b0);
        end
        for (int i = 15; i >= 0; i--) begin
            if (i == 11) fmt_sel = 1'b0;
            send_bit(1'(16'h3C3C >> i), 1'b0, 1'b0, 1'b0);
        end
        e.l = 16'hC3C3; e.r = 16'h3C3C; e.tag = "R8";
        sb_q.push_back(e);
        mux_frame(32'h0F0F, 16, 32'hF0F0, 16, 1'b1, "R8");
        send_bit(1'b0, 1'b0, 1'b1, 1'b0);
        drained("R5 R2");

        // multiplexed, left while word-select low, then switch format
        aux_pin = 1'b0; ws = 1'b0;
        do_reset();
        mux_frame(32'h1111, 16, 32'h2222, 16, 1'b0, "R3");
        mux_frame(32'h8001, 16, 32'hFFFE, 16, 1'b0, "R3");
        send_word(32'h4444, 32'h0, 16, 1'b0, 1'b0);
        for (int i = 15; i >= 0; i--) begin
            if (i == 8) fmt_sel = 1'b1;
            send_bit(1'(16'h5555 >> i), 1'b0, 1'b1, 1'b0);
        end
        e.l = 16'h4444; e.r = 16'h5555; e.tag = "R3 R8";
        sb_q.push_back(e);
        sim_frame(32'h6666, 32'h7777, 16, 1'b0, "R4 R8");
        sim_frame(32'h89AB, 32'hCDEF, 16, 1'b1, "R4 R10");
        sim_frame(32'hABC, 32'h123, 12, 1'b0, "R4 R7");
        sim_frame(32'h28001, 32'h17FFE, 18, 1'b1, "R4 R6");
        send_bit(1'b0, 1'b0, 1'b0, 1'b1);
        drained("R5 R4");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule